// File: doc/BRIEF.md
# Interrupt Vector Ring Drain

This block consumes interrupt vectors from a circular ring that a producer fills. Each vector occupies 16 bytes. The producer reports its write pointer as a byte offset, together with a flag that signals the ring has overrun. Whenever the block's own read pointer differs from the write pointer, it fetches the vector at the read pointer. It fetches through a dword-wide read port with one cycle of latency, and splits the vector into its fields. The fields are offered on a valid/ready stream.

Page-fault vectors can be throttled. The block presents the fault's address-space ID to an external credit source. A fault that carries a nonzero ID with no credit left is dropped silently. When the read pointer catches up with the write pointer, the new read pointer is published once. It goes out either as a doorbell write or as an update of a pointer register, chosen by a configuration input. On an overrun, the block skips ahead to the oldest vector that is still intact and tells the producer to clear the flag.

Top module: `irq_ring_drain`

## Requirements
- R1: After reset `ent_valid`, `db_wr`, `reg_wr` and `ovf_clear` are low and `rptr_reg` is zero.
- R2: While idle and enabled, a high `wptr_ovf` sets the read pointer to (`wptr` + 16) modulo the ring size. It also raises `ovf_clear` for exactly one cycle, and the flag is ignored in the cycle that follows the pulse. Draining then starts from the new read pointer.
- R3: Dword k (k = 0, 1, 2) of a vector is read at dword address (read pointer >> 2) + k modulo the ring's dword count, so vectors wrap around the end of the ring.
- R4: A delivered entry carries these fields:
  - source ID = dword 0 bits [7:0]
  - source data = dword 1 bits [27:0]
  - ring ID = dword 2 bits [7:0]
  - VMID = dword 2 bits [15:8]
  - PASID = dword 2 bits [31:16]

  Every consumed vector, whether delivered or dropped, advances the read pointer by 16.
- R5: A vector whose source ID is anything other than 146 or 147 is always delivered, whatever its PASID and credit.
- R6: For a vector with source ID 146 or 147, the PASID is presented on `credit_pasid`. The vector is delivered if that PASID is zero or `credit_ok` is high. Otherwise it is dropped and no entry appears.
- R7: When the read pointer equals `wptr` after at least one change, the pointer is published once. If `use_doorbell`=1, `db_wr` pulses with `db_ptr` set to the pointer. If `use_doorbell`=0, `reg_wr` pulses and `rptr_reg` takes the pointer. Only one of the two strobes fires.
- R8: While `ent_valid` is high and `ent_ready` is low, `ent_valid` stays high and all entry fields hold their values.
- R9: While `enable` is low the block stays idle and the read pointer is reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Consumer enable; low clears the read pointer |
| use_doorbell | input | 1 | 1 publishes by doorbell, 0 by pointer register |
| wptr | input | PTR_W | Producer write pointer in bytes |
| wptr_ovf | input | 1 | Producer overrun flag |
| mem_rd_en | output | 1 | Ring read request |
| mem_rd_addr | output | PTR_W-2 | Ring dword address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the request |
| credit_pasid | output | 16 | PASID whose fault credit is queried |
| credit_ok | input | 1 | Queried PASID still has credit |
| ent_valid | output | 1 | Decoded entry valid |
| ent_ready | input | 1 | Downstream accepts entry |
| ent_src_id | output | 8 | Source ID |
| ent_src_data | output | 28 | Source data |
| ent_ring_id | output | 8 | Ring ID |
| ent_vmid | output | 8 | VMID |
| ent_pasid | output | 16 | PASID |
| db_wr | output | 1 | Doorbell write strobe |
| db_ptr | output | PTR_W | Doorbell payload (read pointer) |
| reg_wr | output | 1 | Pointer register update strobe |
| rptr_reg | output | PTR_W | Published read-pointer register |
| ovf_clear | output | 1 | Overrun clear pulse |

## Verification
The bench places three vectors so that they straddle the end of the ring, and reaches that position through an overrun jump. A design that failed to wrap the dword address would fetch from beyond the ring. A design that computed the jump target wrongly would deliver the wrong vectors, or a different number of them.

The fault filter is tested with a mix of vectors:
- a no-credit fault with a nonzero PASID, which must be dropped;
- a fault with PASID zero, which must be delivered;
- a credited fault, which must be delivered;
- a non-fault vector that lacks credit, which must be delivered.

A filter keyed on the wrong condition shows up as a wrong entry count or a wrong source sequence. A published pointer that stops short also catches a dropped vector that was never skipped.

Each field is surrounded by set junk bits, so any mis-sliced field changes value. Irregular backpressure exposes entries that change while stalled. Batch publication is checked by counting strobes on both publish paths.

// File: rtl/irq_ring_drain.sv
module irq_ring_drain #(
  parameter int PTR_W   = 10,
  parameter int FAULT_A = 146,
  parameter int FAULT_B = 147
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             use_doorbell,
  input  logic [PTR_W-1:0] wptr,
  input  logic             wptr_ovf,
  output logic             mem_rd_en,
  output logic [PTR_W-3:0] mem_rd_addr,
  input  logic [31:0]      mem_rd_data,
  output logic [15:0]      credit_pasid,
  input  logic             credit_ok,
  output logic             ent_valid,
  input  logic             ent_ready,
  output logic [7:0]       ent_src_id,
  output logic [27:0]      ent_src_data,
  output logic [7:0]       ent_ring_id,
  output logic [7:0]       ent_vmid,
  output logic [15:0]      ent_pasid,
  output logic             db_wr,
  output logic [PTR_W-1:0] db_ptr,
  output logic             reg_wr,
  output logic [PTR_W-1:0] rptr_reg,
  output logic             ovf_clear
);
  localparam int IDX_W = PTR_W - 2;
  localparam logic [PTR_W-1:0] VEC_BYTES = PTR_W'(16);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_CHK, S_OUT} st_t;

  st_t              st;
  logic [PTR_W-1:0] rptr;
  logic             dirty;
  logic [1:0]       rcnt;
  logic             pend;
  logic [1:0]       pidx;
  logic [31:0]      dw0, dw1, dw2;

  logic is_fault, drop;

  assign mem_rd_en    = (st == S_RD) && (rcnt != 2'd3);
  assign mem_rd_addr  = rptr[PTR_W-1:2] + IDX_W'(rcnt);

  assign ent_src_id   = dw0[7:0];
  assign ent_src_data = dw1[27:0];
  assign ent_ring_id  = dw2[7:0];
  assign ent_vmid     = dw2[15:8];
  assign ent_pasid    = dw2[31:16];
  assign credit_pasid = dw2[31:16];
  assign ent_valid    = (st == S_OUT);

  assign is_fault = (dw0[7:0] == 8'(FAULT_A)) || (dw0[7:0] == 8'(FAULT_B));
  assign drop     = is_fault && (dw2[31:16] != 16'd0) && !credit_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rptr      <= '0;
      dirty     <= 1'b0;
      rcnt      <= '0;
      pend      <= 1'b0;
      pidx      <= '0;
      dw0       <= '0;
      dw1       <= '0;
      dw2       <= '0;
      db_wr     <= 1'b0;
      db_ptr    <= '0;
      reg_wr    <= 1'b0;
      rptr_reg  <= '0;
      ovf_clear <= 1'b0;
    end else begin
      db_wr     <= 1'b0;
      reg_wr    <= 1'b0;
      ovf_clear <= 1'b0;
      pend      <= mem_rd_en;
      pidx      <= rcnt;
      if (mem_rd_en) rcnt <= rcnt + 2'd1;
      if (pend) begin
        case (pidx)
          2'd0:    dw0 <= mem_rd_data;
          2'd1:    dw1 <= mem_rd_data;
          default: dw2 <= mem_rd_data;
        endcase
      end
      case (st)
        S_IDLE: begin
          if (!enable) begin
            rptr  <= '0;
            dirty <= 1'b0;
          end else if (wptr_ovf && !ovf_clear) begin
            rptr      <= wptr + VEC_BYTES;
            ovf_clear <= 1'b1;
            dirty     <= 1'b1;
          end else if (rptr != wptr) begin
            st   <= S_RD;
            rcnt <= '0;
          end else if (dirty) begin
            dirty <= 1'b0;
            if (use_doorbell) begin
              db_wr  <= 1'b1;
              db_ptr <= rptr;
            end else begin
              reg_wr   <= 1'b1;
              rptr_reg <= rptr;
            end
          end
        end
        S_RD: if (pend && pidx == 2'd2) st <= S_CHK;
        S_CHK: begin
          if (drop) begin
            rptr  <= rptr + VEC_BYTES;
            dirty <= 1'b1;
            st    <= S_IDLE;
          end else begin
            st <= S_OUT;
          end
        end
        S_OUT: begin
          if (ent_ready) begin
            rptr  <= rptr + VEC_BYTES;
            dirty <= 1'b1;
            st    <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_ovf_clear_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clear |=> !ovf_clear);

  p_ovf_jump_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && enable && wptr_ovf && !ovf_clear) |=> (rptr == $past(wptr) + VEC_BYTES));

  p_stall_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && !ent_ready) |=> (ent_valid && $stable(ent_src_id) && $stable(ent_src_data)
      && $stable(ent_ring_id) && $stable(ent_vmid) && $stable(ent_pasid)));

  p_one_publish_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({db_wr, reg_wr}));

  p_drop_no_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHK && drop) |=> !ent_valid);

  p_disabled_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !enable) |=> (rptr == '0 && !ent_valid));
endmodule

// File: tb/tb_irq_ring_drain.sv
module tb_irq_ring_drain;
  localparam int CLK_PERIOD = 10;
  localparam int PTR_W = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, use_doorbell = 1'b1;
  logic [PTR_W-1:0] wptr = '0;
  logic wptr_ovf = 1'b0;
  logic mem_rd_en;
  logic [PTR_W-3:0] mem_rd_addr;
  logic [31:0] mem_rd_data = '0;
  logic [15:0] credit_pasid;
  logic credit_ok;
  logic ent_valid, ent_ready = 1'b1;
  logic [7:0] ent_src_id, ent_ring_id, ent_vmid;
  logic [27:0] ent_src_data;
  logic [15:0] ent_pasid;
  logic db_wr, reg_wr, ovf_clear;
  logic [PTR_W-1:0] db_ptr, rptr_reg;

  int checks = 0, failures = 0;
  logic [31:0] ring [0:(1<<(PTR_W-2))-1];
  logic [15:0] credited = 16'h0042;

  logic [7:0]  g_src [0:31];
  logic [27:0] g_data [0:31];
  logic [7:0]  g_ring [0:31];
  logic [7:0]  g_vmid [0:31];
  logic [15:0] g_pasid [0:31];
  int n_got = 0, n_db = 0, n_reg = 0, n_ovfc = 0;
  logic stalled = 1'b0;
  logic [67:0] held;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign credit_ok = (credit_pasid == credited);

  irq_ring_drain #(.PTR_W(PTR_W)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .use_doorbell(use_doorbell),
    .wptr(wptr), .wptr_ovf(wptr_ovf), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .credit_pasid(credit_pasid), .credit_ok(credit_ok),
    .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_src_id(ent_src_id),
    .ent_src_data(ent_src_data), .ent_ring_id(ent_ring_id), .ent_vmid(ent_vmid),
    .ent_pasid(ent_pasid), .db_wr(db_wr), .db_ptr(db_ptr), .reg_wr(reg_wr),
    .rptr_reg(rptr_reg), .ovf_clear(ovf_clear));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= ring[mem_rd_addr];
    if (rst_n) begin
      if (stalled) check("R8 stall hold", {31'd0, ent_valid} ^ 32'(({ent_src_id, ent_src_data, ent_ring_id, ent_vmid, ent_pasid} != held)), 32'd1);
      stalled <= ent_valid && !ent_ready;
      held    <= {ent_src_id, ent_src_data, ent_ring_id, ent_vmid, ent_pasid};
      if (ent_valid && ent_ready) begin
        g_src[n_got%32] <= ent_src_id;  g_data[n_got%32] <= ent_src_data;
        g_ring[n_got%32] <= ent_ring_id; g_vmid[n_got%32] <= ent_vmid;
        g_pasid[n_got%32] <= ent_pasid;
        n_got <= n_got + 1;
      end
      if (db_wr) n_db <= n_db + 1;
      if (reg_wr) n_reg <= n_reg + 1;
      if (ovf_clear) n_ovfc <= n_ovfc + 1;
    end
  end

  task automatic put_vec(int baddr, logic [7:0] src, logic [27:0] data, logic [7:0] rid,
                         logic [7:0] vmid, logic [15:0] pasid);
    ring[(baddr>>2)%256]   = {24'hA5A5A5, src};
    ring[(baddr>>2)%256+1] = {4'hF, data};
    ring[(baddr>>2)%256+2] = {pasid, vmid, rid};
    ring[(baddr>>2)%256+3] = 32'hDEADBEEF;
  endtask

  task automatic clr_counts();
    @(negedge clk);
    n_got = 0; n_db = 0; n_reg = 0; n_ovfc = 0;
  endtask

  task automatic chk_ent(string req, int i, logic [7:0] src, logic [27:0] data,
                         logic [7:0] rid, logic [7:0] vmid, logic [15:0] pasid);
    check(req, 32'(g_src[i]), 32'(src));
    check(req, 32'(g_data[i]), 32'(data));
    check(req, 32'(g_ring[i]), 32'(rid));
    check(req, 32'(g_vmid[i]), 32'(vmid));
    check(req, 32'(g_pasid[i]), 32'(pasid));
  endtask

  task automatic t_reset();
    check("R1 ent_valid", 32'(ent_valid), 0);
    check("R1 db_wr", 32'(db_wr), 0);
    check("R1 reg_wr", 32'(reg_wr), 0);
    check("R1 ovf_clear", 32'(ovf_clear), 0);
    check("R1 rptr_reg", 32'(rptr_reg), 0);
  endtask

  task automatic t_basic();
    put_vec(0, 8'h21, 28'h1234567, 8'h01, 8'h02, 16'h0003);
    put_vec(16, 8'h22, 28'h0ABCDEF, 8'h11, 8'h12, 16'hBEEF);
    put_vec(32, 8'hFF, 28'h0000001, 8'hE0, 8'h7F, 16'h8001);
    clr_counts();
    wptr = 10'd48;
    repeat (120) @(negedge clk);
    check("R4 count", 32'(n_got), 3);
    chk_ent("R4 fields v0", 0, 8'h21, 28'h1234567, 8'h01, 8'h02, 16'h0003);
    chk_ent("R4 fields v1", 1, 8'h22, 28'h0ABCDEF, 8'h11, 8'h12, 16'hBEEF);
    chk_ent("R5 fields v2", 2, 8'hFF, 28'h0000001, 8'hE0, 8'h7F, 16'h8001);
    check("R7 one doorbell", 32'(n_db), 1);
    check("R7 doorbell ptr", 32'(db_ptr), 48);
    check("R7 no reg write", 32'(n_reg), 0);
  endtask

  task automatic t_filter();
    put_vec(48, 8'd146, 28'h0000AAA, 8'h01, 8'h01, 16'h0005);
    put_vec(64, 8'd147, 28'h0000BBB, 8'h02, 8'h02, 16'h0000);
    put_vec(80, 8'd146, 28'h0000CCC, 8'h03, 8'h03, 16'h0042);
    put_vec(96, 8'd9,   28'h0000DDD, 8'h04, 8'h04, 16'h0007);
    clr_counts();
    wptr = 10'd112;
    repeat (160) @(negedge clk);
    check("R6 delivered count", 32'(n_got), 3);
    chk_ent("R6 pasid zero passes", 0, 8'd147, 28'h0000BBB, 8'h02, 8'h02, 16'h0000);
    chk_ent("R6 credited passes", 1, 8'd146, 28'h0000CCC, 8'h03, 8'h03, 16'h0042);
    chk_ent("R5 non-fault passes", 2, 8'd9, 28'h0000DDD, 8'h04, 8'h04, 16'h0007);
    check("R6 drop advances ptr", 32'(db_ptr), 112);
    check("R7 one doorbell", 32'(n_db), 1);
  endtask

  task automatic t_regmode();
    use_doorbell = 1'b0;
    put_vec(112, 8'h30, 28'h0000123, 8'h05, 8'h06, 16'h0000);
    clr_counts();
    wptr = 10'd128;
    repeat (60) @(negedge clk);
    check("R7 reg count", 32'(n_reg), 1);
    check("R7 rptr_reg", 32'(rptr_reg), 128);
    check("R7 no doorbell", 32'(n_db), 0);
    check("R4 reg mode entry", 32'(g_src[0]), 32'h30);
    use_doorbell = 1'b1;
  endtask

  task automatic t_backpressure();
    put_vec(128, 8'h41, 28'h0000041, 8'h41, 8'h41, 16'h0041);
    put_vec(144, 8'h42, 28'h0000042, 8'h42, 8'h42, 16'h0042);
    clr_counts();
    wptr = 10'd160;
    for (int c = 0; c < 200; c++) begin
      ent_ready = (c % 5 == 4);
      @(negedge clk);
    end
    ent_ready = 1'b1;
    repeat (20) @(negedge clk);
    check("R8 count", 32'(n_got), 2);
    chk_ent("R8 v0", 0, 8'h41, 28'h0000041, 8'h41, 8'h41, 16'h0041);
    chk_ent("R8 v1", 1, 8'h42, 28'h0000042, 8'h42, 8'h42, 16'h0042);
  endtask

  task automatic t_disable();
    enable = 1'b0;
    wptr = 10'd0;
    repeat (5) @(negedge clk);
    put_vec(0, 8'h55, 28'h0000055, 8'h55, 8'h55, 16'h0000);
    clr_counts();
    enable = 1'b1;
    wptr = 10'd16;
    repeat (60) @(negedge clk);
    check("R9 restart count", 32'(n_got), 1);
    check("R9 restart src", 32'(g_src[0]), 32'h55);
    check("R9 restart ptr", 32'(db_ptr), 16);
  endtask

  task automatic t_overflow_wrap();
    put_vec(10'h3F0, 8'h61, 28'h0000061, 8'h61, 8'h61, 16'h0000);
    put_vec(10'h000, 8'h62, 28'h0000062, 8'h62, 8'h62, 16'h0000);
    put_vec(10'h010, 8'h63, 28'h0000063, 8'h63, 8'h63, 16'h0000);
    clr_counts();
    wptr = 10'h3E0;
    wptr_ovf = 1'b1;
    for (int c = 0; c < 10 && !ovf_clear; c++) @(negedge clk);
    wptr_ovf = 1'b0;
    wptr = 10'h020;
    repeat (150) @(negedge clk);
    check("R2 ovf_clear pulses", 32'(n_ovfc), 1);
    check("R3 wrap count", 32'(n_got), 3);
    check("R2 first after jump", 32'(g_src[0]), 32'h61);
    check("R3 wrapped v1", 32'(g_src[1]), 32'h62);
    check("R3 wrapped v2", 32'(g_src[2]), 32'h63);
    check("R2 final ptr", 32'(db_ptr), 32'h020);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ring[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    enable = 1'b1;
    t_basic();
    t_filter();
    t_regmode();
    t_backpressure();
    t_disable();
    t_overflow_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule